// File: doc/BRIEF.md
# 8b/10b Character Decoder with Fault Capture

This block sits behind a character aligner in a serial receive path. Each cycle in which the aligner marks a 10-bit character as valid, the block turns that character into a byte and a control flag. It keeps track of the running disparity of the stream and tests every character for two faults. The first is an illegal code word, a pattern that no byte or control code produces at either disparity. The second is a disparity violation, a legal pattern that belongs to the running disparity opposite to the current one.

The decoded byte and the control flag appear one clock after the character, together with a valid strobe and two per-character fault flags. Any fault also sets a sticky status bit. The status bit stays set until a read-clear strobe arrives, and the register front end reads it from that strobe. When the overlay-select input is high, faults are also shown on a loss-of-signal output, so that a link monitor can act on them without reading the status bit.

Top module: `tenbit_decoder`

## Requirements
- R1: After reset, `dat_valid_o`, `code_err_o`, `disp_err_o`, `err_status_o` and `los_o` are 0, and the running disparity is negative. A first character encoded for negative disparity raises no disparity fault, and one encoded for positive disparity raises one.
- R2: Each character with `sym_valid_i` high produces `dat_valid_o` high on the following cycle. Each character with `sym_valid_i` low produces `dat_valid_o` low on that cycle.
- R3: Character bit order is `sym_i[9:4]` = 6-bit sub-block abcdei (a in bit 9) and `sym_i[3:0]` = 4-bit sub-block fghj (f in bit 3). The output byte is HGFEDCBA with EDCBA in `dat_o[4:0]`. Every legal data character decodes to its byte with `dat_k_o` = 0.
- R4: The twelve control characters (K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7) decode to their byte with `dat_k_o` = 1, at either disparity.
- R5: `code_err_o` is 1 for a character that matches no legal data or control character at either disparity.
- R6: `disp_err_o` is 1 for a legal character whose encoding belongs to the disparity opposite the current running disparity. `code_err_o` and `disp_err_o` are never both 1.
- R7: Running disparity is updated by every valid character, faulty ones included. The 6-bit sub-block sets it positive if it has more ones than zeros or equals 000111, and negative if it has fewer ones or equals 111000. Otherwise the sub-block leaves it unchanged. The 4-bit sub-block then applies the same rule, with 0011 setting it positive and 1100 setting it negative.
- R8: A fault on a valid character sets `err_status_o` on the same cycle that the fault flags appear. The bit stays set until `status_rdclr_i` is sampled high.
- R9: A clear with no new fault drops `err_status_o` on the next cycle. A clear in the same cycle as a new fault leaves it set.
- R10: `los_o` is high on the output cycle of a faulty character only if `los_overlay_i` was high together with that character. Otherwise it is low.
- R11: Characters with `sym_valid_i` low are ignored. They change neither the running disparity nor the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid_i | input | 1 | Character on sym_i is aligned and valid |
| sym_i | input | 10 | Received character, abcdei fghj from bit 9 down |
| los_overlay_i | input | 1 | Show faults on los_o |
| status_rdclr_i | input | 1 | Read-clear strobe for err_status_o |
| dat_valid_o | output | 1 | Decoded outputs valid |
| dat_o | output | 8 | Decoded byte HGFEDCBA |
| dat_k_o | output | 1 | Decoded character is a control character |
| code_err_o | output | 1 | Character was an illegal code word |
| disp_err_o | output | 1 | Character violated running disparity |
| err_status_o | output | 1 | Sticky fault status |
| los_o | output | 1 | Loss-of-signal fault indication |

## Verification
The assertions assume that `sym_valid_i`, `los_overlay_i` and `status_rdclr_i` are clean 0 or 1 levels on each edge. They make no assumption about how valid and idle cycles alternate, or about when the clear strobe arrives relative to faults. The random stimulus drives idle cycles, read-clear strobes at any time, and overlay toggling independently of each other. Characters are a mix of correctly encoded ones, characters encoded at the wrong disparity, and arbitrary 10-bit patterns, so faults and clears collide freely. Directed steps cover the first character after reset, every control character, and a clear that coincides with a fault.

// File: rtl/tenbit_pkg.sv
package tenbit_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int S6_W   = 6;
  localparam int S4_W   = 4;
  localparam int XCNT   = 1 << 5;
  localparam int YCNT   = 1 << 3;

  // 6-bit sub-block emitted when running disparity is negative
  function automatic logic [S6_W-1:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  six_neg = 6'b100111; 5'd1:  six_neg = 6'b011101;
      5'd2:  six_neg = 6'b101101; 5'd3:  six_neg = 6'b110001;
      5'd4:  six_neg = 6'b110101; 5'd5:  six_neg = 6'b101001;
      5'd6:  six_neg = 6'b011001; 5'd7:  six_neg = 6'b111000;
      5'd8:  six_neg = 6'b111001; 5'd9:  six_neg = 6'b100101;
      5'd10: six_neg = 6'b010101; 5'd11: six_neg = 6'b110100;
      5'd12: six_neg = 6'b001101; 5'd13: six_neg = 6'b101100;
      5'd14: six_neg = 6'b011100; 5'd15: six_neg = 6'b010111;
      5'd16: six_neg = 6'b011011; 5'd17: six_neg = 6'b100011;
      5'd18: six_neg = 6'b010011; 5'd19: six_neg = 6'b110010;
      5'd20: six_neg = 6'b001011; 5'd21: six_neg = 6'b101010;
      5'd22: six_neg = 6'b011010; 5'd23: six_neg = 6'b111010;
      5'd24: six_neg = 6'b110011; 5'd25: six_neg = 6'b100110;
      5'd26: six_neg = 6'b010110; 5'd27: six_neg = 6'b110110;
      5'd28: six_neg = 6'b001110; 5'd29: six_neg = 6'b101110;
      5'd30: six_neg = 6'b011110; default: six_neg = 6'b101011;
    endcase
  endfunction

  // 4-bit sub-block for data at negative disparity (primary .7)
  function automatic logic [S4_W-1:0] four_neg(input logic [2:0] y);
    case (y)
      3'd0: four_neg = 4'b1011; 3'd1: four_neg = 4'b1001;
      3'd2: four_neg = 4'b0101; 3'd3: four_neg = 4'b1100;
      3'd4: four_neg = 4'b1101; 3'd5: four_neg = 4'b1010;
      3'd6: four_neg = 4'b0110; default: four_neg = 4'b1110;
    endcase
  endfunction

  // 4-bit sub-block of K28.y at negative starting disparity
  function automatic logic [S4_W-1:0] four_k28(input logic [2:0] y);
    case (y)
      3'd0: four_k28 = 4'b0100; 3'd1: four_k28 = 4'b1001;
      3'd2: four_k28 = 4'b0101; 3'd3: four_k28 = 4'b0011;
      3'd4: four_k28 = 4'b0010; 3'd5: four_k28 = 4'b1010;
      3'd6: four_k28 = 4'b0110; default: four_k28 = 4'b1000;
    endcase
  endfunction

  function automatic logic [SYM_W-1:0] encode(input logic [BYTE_W-1:0] v,
                                              input logic k, input logic pos);
    logic [4:0] x;
    logic [2:0] y;
    logic [S6_W-1:0] s6;
    logic [S4_W-1:0] s4;
    logic rd1;
    logic alt;
    x = v[4:0];
    y = v[7:5];
    if (k) begin
      if (x == 5'd28) encode = {6'b001111, four_k28(y)};
      else            encode = {six_neg(x), 4'b1000};
      if (pos) encode = ~encode;
    end else begin
      s6 = six_neg(x);
      if ($countones(s6) != 3) begin
        if (pos) s6 = ~s6;
        rd1 = ~pos;
      end else begin
        rd1 = pos;
        if (x == 5'd7 && pos) s6 = ~s6;
      end
      s4  = four_neg(y);
      alt = (!rd1 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
            ( rd1 && (x == 5'd11 || x == 5'd13 || x == 5'd14));
      if (y == 3'd7 && alt) s4 = 4'b0111;
      if (rd1 && (y == 3'd0 || y == 3'd3 || y == 3'd4 || y == 3'd7)) s4 = ~s4;
      encode = {s6, s4};
    end
  endfunction

  // running disparity after both sub-blocks of a character
  function automatic logic next_rd(input logic [SYM_W-1:0] s, input logic rd_in);
    logic [S6_W-1:0] a;
    logic [S4_W-1:0] b;
    a = s[9:4];
    b = s[3:0];
    next_rd = rd_in;
    if ($countones(a) > 3 || a == 6'b000111)      next_rd = 1'b1;
    else if ($countones(a) < 3 || a == 6'b111000) next_rd = 1'b0;
    if ($countones(b) > 2 || b == 4'b0011)        next_rd = 1'b1;
    else if ($countones(b) < 2 || b == 4'b1100)   next_rd = 1'b0;
  endfunction
endpackage

// File: rtl/sym_lookup.sv
module sym_lookup
  import tenbit_pkg::*;
(
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              k_o,
  output logic              code_err_o,
  output logic              disp_err_o
);
  logic [S6_W-1:0] s6, c6;
  logic [S4_W-1:0] s4, s4k, c4;
  logic [4:0] x;
  logic [2:0] y;
  logic k28, kx7, alt4;
  logic [SYM_W-1:0] exp_n, exp_p;

  always_comb begin
    s6  = sym_i[9:4];
    s4  = sym_i[3:0];
    x   = '0;
    y   = '0;
    c6  = '0;
    c4  = '0;
    k28 = (s6 == 6'b001111) || (s6 == 6'b110000);
    s4k = (s6 == 6'b110000) ? ~s4 : s4;
    for (int i = 0; i < XCNT; i++) begin
      c6 = six_neg(5'(i));
      if (s6 == c6 || (s6 == ~c6 && ($countones(c6) != 3 || i == 7))) x = 5'(i);
    end
    if (k28) x = 5'd28;
    for (int j = 0; j < YCNT; j++) begin
      if (k28) begin
        if (s4k == four_k28(3'(j))) y = 3'(j);
      end else begin
        c4 = four_neg(3'(j));
        if (s4 == c4 || (s4 == ~c4 && (j == 0 || j == 3 || j == 4 || j == 7))) y = 3'(j);
      end
    end
    alt4 = (s4 == 4'b0111) || (s4 == 4'b1000);
    if (!k28 && alt4) y = 3'd7;
    kx7 = !k28 && alt4 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30);
  end

  assign byte_o     = {y, x};
  assign k_o        = k28 | kx7;
  assign exp_n      = encode(byte_o, k_o, 1'b0);
  assign exp_p      = encode(byte_o, k_o, 1'b1);
  assign code_err_o = (sym_i != exp_n) && (sym_i != exp_p);
  assign disp_err_o = !code_err_o && (sym_i != (rd_i ? exp_p : exp_n));
endmodule

// File: rtl/disp_tracker.sv
module disp_tracker
  import tenbit_pkg::*;
#(
  parameter logic RD_RESET = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             rd_o
);
  always_ff @(posedge clk) begin
    if (rst)       rd_o <= RD_RESET;
    else if (en_i) rd_o <= next_rd(sym_i, rd_o);
  end

  // R11: idle cycles leave running disparity untouched
  assert_rd_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(rd_o));
  // R7: an all-ones-heavy character always ends positive
  assert_rd_heavy_pos_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && $countones(sym_i[3:0]) > 2) |=> rd_o);
endmodule

// File: rtl/fault_status.sv
module fault_status (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic clr_i,
  input  logic overlay_i,
  output logic status_o,
  output logic los_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= 1'b0;
      los_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_i) | fault_i;
      los_o    <= fault_i & overlay_i;
    end
  end

  // R8: set bit survives until a clear
  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status_o && !clr_i) |=> status_o);
  // R9: clear without a fault empties the bit
  assert_status_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !fault_i) |=> !status_o);
  // R9: a fault wins over a simultaneous clear
  assert_status_fault_wins_R9: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> status_o);
endmodule

// File: rtl/tenbit_decoder.sv
module tenbit_decoder
  import tenbit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sym_valid_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              los_overlay_i,
  input  logic              status_rdclr_i,
  output logic              dat_valid_o,
  output logic [BYTE_W-1:0] dat_o,
  output logic              dat_k_o,
  output logic              code_err_o,
  output logic              disp_err_o,
  output logic              err_status_o,
  output logic              los_o
);
  logic              rd;
  logic [BYTE_W-1:0] lk_byte;
  logic              lk_k, lk_code, lk_disp, fault;

  sym_lookup u_lookup (
    .sym_i      (sym_i),
    .rd_i       (rd),
    .byte_o     (lk_byte),
    .k_o        (lk_k),
    .code_err_o (lk_code),
    .disp_err_o (lk_disp)
  );

  disp_tracker #(.RD_RESET(1'b0)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .en_i  (sym_valid_i),
    .sym_i (sym_i),
    .rd_o  (rd)
  );

  assign fault = sym_valid_i & (lk_code | lk_disp);

  fault_status u_status (
    .clk       (clk),
    .rst       (rst),
    .fault_i   (fault),
    .clr_i     (status_rdclr_i),
    .overlay_i (los_overlay_i),
    .status_o  (err_status_o),
    .los_o     (los_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_valid_o <= 1'b0;
      dat_o       <= '0;
      dat_k_o     <= 1'b0;
      code_err_o  <= 1'b0;
      disp_err_o  <= 1'b0;
    end else begin
      dat_valid_o <= sym_valid_i;
      if (sym_valid_i) begin
        dat_o   <= lk_byte;
        dat_k_o <= lk_k;
      end
      code_err_o <= sym_valid_i & lk_code;
      disp_err_o <= sym_valid_i & lk_disp;
    end
  end

  // R2: one cycle from character to decoded output
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    sym_valid_i |=> dat_valid_o);
  assert_idle_latency_R2: assert property (@(posedge clk) disable iff (rst)
    !sym_valid_i |=> !dat_valid_o);
  // R6: the two fault kinds exclude each other
  assert_fault_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(code_err_o && disp_err_o));
  // R10: loss-of-signal only accompanies a reported fault
  assert_los_needs_fault_R10: assert property (@(posedge clk) disable iff (rst)
    los_o |-> (dat_valid_o && (code_err_o || disp_err_o)));
  // R8: a reported fault is reflected in the status bit
  assert_fault_sets_status_R8: assert property (@(posedge clk) disable iff (rst)
    (code_err_o || disp_err_o) |-> err_status_o);
endmodule

// File: tb/sim_tenbit_decoder.sv
module sim_tenbit_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic clk = 1'b0;
  logic rst;
  logic sym_valid_i, los_overlay_i, status_rdclr_i;
  logic [9:0] sym_i;
  logic dat_valid_o, dat_k_o, code_err_o, disp_err_o, err_status_o, los_o;
  logic [7:0] dat_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic m_rd, m_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  tenbit_decoder u0 (
    .clk(clk), .rst(rst), .sym_valid_i(sym_valid_i), .sym_i(sym_i),
    .los_overlay_i(los_overlay_i), .status_rdclr_i(status_rdclr_i),
    .dat_valid_o(dat_valid_o), .dat_o(dat_o), .dat_k_o(dat_k_o),
    .code_err_o(code_err_o), .disp_err_o(disp_err_o),
    .err_status_o(err_status_o), .los_o(los_o)
  );

  function automatic logic [5:0] t6(input logic [4:0] x);
    logic [5:0] t [32];
    t = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
          6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
          6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
          6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
          6'b011110, 6'b101011};
    return t[x];
  endfunction

  function automatic logic [9:0] benc(input logic [7:0] v, input logic k, input logic pos);
    logic [3:0] dn [8];
    logic [3:0] kn [8];
    logic [5:0] a;
    logic [3:0] b;
    logic r;
    dn = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    kn = '{4'b0100, 4'b1001, 4'b0101, 4'b0011, 4'b0010, 4'b1010, 4'b0110, 4'b1000};
    if (k) begin
      a = (v[4:0] == 5'd28) ? 6'b001111 : t6(v[4:0]);
      b = (v[4:0] == 5'd28) ? kn[v[7:5]] : 4'b1000;
      return pos ? ~{a, b} : {a, b};
    end
    a = t6(v[4:0]);
    r = pos;
    if ($countones(a) != 3) begin a = pos ? ~a : a; r = ~pos; end
    else if (v[4:0] == 5'd7 && pos) a = ~a;
    b = dn[v[7:5]];
    if (v[7:5] == 3'd7 && ((!r && (v[4:0] inside {5'd17, 5'd18, 5'd20})) ||
                           (r && (v[4:0] inside {5'd11, 5'd13, 5'd14})))) b = 4'b0111;
    if (r && (v[7:5] inside {3'd0, 3'd3, 3'd4, 3'd7})) b = ~b;
    return {a, b};
  endfunction

  function automatic logic [7:0] kbyte(input int i);
    logic [7:0] extra [4];
    extra = '{8'hF7, 8'hFB, 8'hFD, 8'hFE};
    if (i < 8) return {3'(i), 5'd28};
    return extra[i-8];
  endfunction

  function automatic bit bfind(input logic [9:0] s, output logic [7:0] v, output logic k);
    v = '0; k = 1'b0;
    for (int i = 0; i < 256; i++)
      if (s == benc(8'(i), 1'b0, 1'b0) || s == benc(8'(i), 1'b0, 1'b1)) begin
        v = 8'(i); return 1'b1;
      end
    for (int i = 0; i < 12; i++)
      if (s == benc(kbyte(i), 1'b1, 1'b0) || s == benc(kbyte(i), 1'b1, 1'b1)) begin
        v = kbyte(i); k = 1'b1; return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic logic brd(input logic [9:0] s, input logic r);
    logic q;
    q = r;
    if (s[9:4] == 6'b000111 || $countones(s[9:4]) > 3) q = 1'b1;
    else if (s[9:4] == 6'b111000 || $countones(s[9:4]) < 3) q = 1'b0;
    if (s[3:0] == 4'b0011 || $countones(s[3:0]) > 2) q = 1'b1;
    else if (s[3:0] == 4'b1100 || $countones(s[3:0]) < 2) q = 1'b0;
    return q;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, check the result one cycle later
  task automatic step(input logic v, input logic [9:0] s, input logic ov, input logic clr);
    logic [7:0] ev;
    logic ek, found, ecode, edisp;
    found = bfind(s, ev, ek);
    ecode = v && !found;
    edisp = v && found && (s != benc(ev, ek, m_rd));
    sym_valid_i = v; sym_i = s; los_overlay_i = ov; status_rdclr_i = clr;
    m_status = (m_status && !clr) || ecode || edisp;
    if (v) m_rd = brd(s, m_rd);
    @(negedge clk);
    chk("R2", "valid", int'(dat_valid_o), int'(v));
    chk(v ? "R5" : "R11", "code_err", int'(code_err_o), int'(ecode));
    chk("R6/R7", "disp_err", int'(disp_err_o), int'(edisp));
    if (v && found) begin
      chk(ek ? "R4" : "R3", "byte", int'(dat_o), int'(ev));
      chk(ek ? "R4" : "R3", "k flag", int'(dat_k_o), int'(ek));
    end
    chk(v ? "R8/R9" : "R11", "status", int'(err_status_o), int'(m_status));
    chk("R10", "los", int'(los_o), int'(ov && (ecode || edisp)));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    logic [7:0] b;
    r = $urandom(32'd20240611);
    rst = 1'b1; sym_valid_i = 1'b0; sym_i = '0; los_overlay_i = 1'b0; status_rdclr_i = 1'b0;
    m_rd = 1'b0; m_status = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid", int'(dat_valid_o), 0);
    chk("R1", "status", int'(err_status_o), 0);
    chk("R1", "los", int'(los_o), 0);
    chk("R1", "errors", int'(code_err_o | disp_err_o), 0);
    rst = 1'b0;
    // R1: first character at positive disparity is a disparity fault (K28.5)
    step(1'b1, benc(8'hBC, 1'b1, 1'b1), 1'b1, 1'b0);
    rst = 1'b1; @(negedge clk); rst = 1'b0; m_rd = 1'b0; m_status = 1'b0;
    // R1: first character at negative disparity is clean
    step(1'b1, benc(8'hBC, 1'b1, 1'b0), 1'b1, 1'b0);
    // R4: every control character, with correct disparity
    for (int i = 0; i < 12; i++) step(1'b1, benc(kbyte(i), 1'b1, m_rd), 1'b0, 1'b0);
    // R3: D.x.7 alternate forms and D.7 sub-block
    step(1'b1, benc(8'hF1, 1'b0, m_rd), 1'b0, 1'b0);
    step(1'b1, benc(8'hEB, 1'b0, m_rd), 1'b0, 1'b0);
    step(1'b1, benc(8'h07, 1'b0, m_rd), 1'b0, 1'b0);
    // R5 + R9: illegal word with a simultaneous clear keeps status set
    step(1'b1, 10'b1111111111, 1'b1, 1'b1);
    // R11: idle garbage and idle overlay leave everything alone
    step(1'b0, 10'b0000000000, 1'b1, 1'b0);
    // R9: clear with no fault
    step(1'b0, 10'b0, 1'b0, 1'b1);
    // R7: a faulty all-zero character still moves disparity negative
    step(1'b1, 10'b0000000000, 1'b0, 1'b0);
    step(1'b1, benc(8'h00, 1'b0, 1'b1), 1'b0, 1'b1);
    // random mix
    for (int n = 0; n < N_RANDOM; n++) begin
      logic v, ov, clr;
      logic [9:0] s;
      int sel;
      r   = $urandom;
      sel = int'(r % 10);
      v   = (sel != 0);
      ov  = r[8];
      clr = (r[15:12] == 4'd0);
      b   = 8'($urandom);
      if (sel <= 6) begin
        if (r[20:18] == 3'd0) s = benc(kbyte(int'(b % 12)), 1'b1, m_rd);
        else s = benc(b, 1'b0, m_rd);
      end else if (sel == 7) s = benc(b, 1'b0, ~m_rd);
      else s = 10'($urandom);
      step(v, s, ov, clr);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule